// File: doc/BRIEF.md
# Opcode-Menu SPI Flash Command Engine

This block is a SPI master for a serial flash part, driven entirely through a small word-addressed register port. Software never hands the engine a raw opcode when it starts a cycle. It first loads an eight-entry opcode menu, with a two-bit transfer type for each entry. It then writes a control word that names a menu slot. The engine sends that slot's opcode, sends a 24-bit address when the slot's type calls for one, and moves up to 64 data bytes between the flash and a local buffer.

A control bit can request that one of two stored prefix opcodes, typically a write enable, goes out in its own chip-select frame right before the main frame. The two frames form one uninterruptible sequence. A one-way lock bit freezes the menu, the type table and the prefix opcodes until reset, so a trusted agent can fix the command set and later software cannot widen it.

Register words, selected by `reg_addr`:

| Word | Contents |
|------|----------|
| 0 | status: busy, done, error, lock |
| 1 | control word |
| 2 | flash address |
| 3 | prefix opcodes |
| 4 | opcode types |
| 5, 6 | opcode menu |
| 16..31 | data buffer |

Top module: `spi_menu_engine`

## Requirements
- R1: Menu entries 0..3 are bytes 0..3 (entry n in bits 8n+7:8n) of word 5, and entries 4..7 are bytes 0..3 of word 6. A control write (word 1) with bit 1 set sends, as the first byte of the main frame, the entry whose index is in control bits 6:4.
- R2: The entry's type is bits 2n+1:2n of word 4: 0 = read without address, 1 = write without address, 2 = read with address, 3 = write with address. Types 2 and 3 send the 24-bit address from word 2 after the opcode, bits 23:16 first. Types 0 and 1 send no address.
- R3: When control bit 14 is set, a data phase of (bits 13:8)+1 bytes, from 1 to 64, follows. Write types send buffer bytes. Read types send 0x00 and store each MISO byte into the buffer. Buffer byte k sits in word 16+k/4, bits 8(k%4)+7:8(k%4).
- R4: When control bit 2 is set, a prefix opcode goes out first as its own one-byte frame: bits 7:0 of word 3 if control bit 3 is 0, and bits 15:8 if it is 1. CS_n stays high for at least 2 SCK periods before the main frame.
- R5: Frames use SPI mode 0 and shift most-significant bit first. SCK is low whenever CS_n is high.
- R6: Status bit 0 reads 1 while a cycle runs. Status bit 2 is set when the cycle ends and stays set until 1 is written to it. Control bit 1 always reads back as 0.
- R7: A control write with bit 1 set during a running cycle sets status bit 3 and starts no further frame. Writing 1 to status bit 3 clears it.
- R8: Writing 1 to status bit 15 sets the lock, which reads back in bit 15 until reset. While it is set, writes to words 3 to 6 are ignored.
- R9: After reset all status bits and the control word read 0, CS_n is high and SCK is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register word select |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for the selected word (combinational) |
| flash_sck | output | 1 | SPI clock |
| flash_cs_n | output | 1 | SPI chip select, active low |
| flash_mosi | output | 1 | Serial data to the flash |
| flash_miso | input | 1 | Serial data from the flash |

## Verification
The bench builds the engine with the smallest SCK divider (two clocks per half period) and a two-period gap between the prefix and main frames. With these values a full 68-byte frame (opcode, address and 64 data bytes) finishes in a few thousand clocks, and a control write issued two clocks after go lands well inside a running frame. A behavioural flash model returns a distinct byte at each frame position. This exposes any shift, packing or lane error on reads. Each captured frame is compared byte for byte against frames built from the menu, type and control values the bench wrote.

// File: rtl/spi_menu_engine.sv
module spi_menu_engine #(
  parameter int CLK_DIV = 2,
  parameter int GAP_SCK = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic [4:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        flash_sck,
  output logic        flash_cs_n,
  output logic        flash_mosi,
  input  logic        flash_miso
);
  localparam int GAP_T = 2 * GAP_SCK * CLK_DIV;
  localparam int CW    = $clog2(GAP_T + 1);
  localparam int NWORD = 16;

  typedef enum logic [1:0] {S_IDLE, S_PRE, S_GAP, S_MAIN} st_t;

  st_t         st;
  logic [CW-1:0] cnt;
  logic        sck_q;
  logic [2:0]  bitc;
  logic [6:0]  idx, last_q;
  logic [7:0]  rx, op_q, pre_q;
  logic [1:0]  typ_q;
  logic        dat_q, done_q, err_q, lock_q;
  logic [14:0] ctrl_q;
  logic [23:0] addr_q;
  logic [15:0] pre_ops, types;
  logic [63:0] menu;
  logic [31:0] dbuf [NWORD];

  logic       busy, tick, go, frame_end, rd_cap;
  logic [2:0] sel;
  logic [7:0] sel_op, tx, buf_byte;
  logic [1:0] sel_typ;
  logic [6:0] hdr;
  logic [5:0] j;

  assign busy      = (st != S_IDLE);
  assign tick      = (cnt == CW'(CLK_DIV - 1));
  assign go        = reg_we && reg_addr == 5'd1 && reg_wdata[1];
  assign sel       = reg_wdata[6:4];
  assign sel_op    = menu[8*sel +: 8];
  assign sel_typ   = types[2*sel +: 2];
  assign hdr       = typ_q[1] ? 7'd4 : 7'd1;
  assign j         = 6'(idx - hdr);
  assign buf_byte  = dbuf[j[5:2]][8*j[1:0] +: 8];
  assign frame_end = tick && sck_q && bitc == 3'd7 && (st == S_PRE || idx == last_q);
  assign rd_cap    = st == S_MAIN && dat_q && !typ_q[0] && idx >= hdr;

  always_comb begin
    if (st == S_PRE)                   tx = pre_q;
    else if (idx == 7'd0)              tx = op_q;
    else if (typ_q[1] && idx == 7'd1)  tx = addr_q[23:16];
    else if (typ_q[1] && idx == 7'd2)  tx = addr_q[15:8];
    else if (typ_q[1] && idx == 7'd3)  tx = addr_q[7:0];
    else                               tx = typ_q[0] ? buf_byte : 8'h00;
  end

  assign flash_cs_n = !(st == S_PRE || st == S_MAIN);
  assign flash_sck  = sck_q;
  assign flash_mosi = flash_cs_n ? 1'b0 : tx[3'd7 - bitc];

  always_comb begin
    case (reg_addr)
      5'd0:    reg_rdata = {16'b0, lock_q, 11'b0, err_q, done_q, 1'b0, busy};
      5'd1:    reg_rdata = {17'b0, ctrl_q};
      5'd2:    reg_rdata = {8'b0, addr_q};
      5'd3:    reg_rdata = {16'b0, pre_ops};
      5'd4:    reg_rdata = {16'b0, types};
      5'd5:    reg_rdata = menu[31:0];
      5'd6:    reg_rdata = menu[63:32];
      default: reg_rdata = reg_addr[4] ? dbuf[reg_addr[3:0]] : 32'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; cnt <= '0; sck_q <= 1'b0; bitc <= '0; idx <= '0; last_q <= '0;
      rx <= '0; op_q <= '0; pre_q <= '0; typ_q <= '0; dat_q <= 1'b0;
      done_q <= 1'b0; err_q <= 1'b0; lock_q <= 1'b0; ctrl_q <= '0; addr_q <= '0;
      pre_ops <= '0; types <= '0; menu <= '0;
      for (int w = 0; w < NWORD; w++) dbuf[w] <= '0;
    end else begin
      if (reg_we) begin
        case (reg_addr)
          5'd0: begin
            if (reg_wdata[2])  done_q <= 1'b0;
            if (reg_wdata[3])  err_q  <= 1'b0;
            if (reg_wdata[15]) lock_q <= 1'b1;
          end
          5'd1: if (busy) begin
                  if (reg_wdata[1]) err_q <= 1'b1;
                end else ctrl_q <= reg_wdata[14:0] & 15'h7ffd;
          5'd2: if (!busy)   addr_q       <= reg_wdata[23:0];
          5'd3: if (!lock_q) pre_ops      <= reg_wdata[15:0];
          5'd4: if (!lock_q) types        <= reg_wdata[15:0];
          5'd5: if (!lock_q) menu[31:0]   <= reg_wdata;
          5'd6: if (!lock_q) menu[63:32]  <= reg_wdata;
          default: if (reg_addr[4] && !busy) dbuf[reg_addr[3:0]] <= reg_wdata;
        endcase
      end

      if (go && !busy) begin
        op_q   <= sel_op;
        typ_q  <= sel_typ;
        dat_q  <= reg_wdata[14];
        pre_q  <= reg_wdata[3] ? pre_ops[15:8] : pre_ops[7:0];
        last_q <= (sel_typ[1] ? 7'd3 : 7'd0) +
                  (reg_wdata[14] ? ({1'b0, reg_wdata[13:8]} + 7'd1) : 7'd0);
        st     <= reg_wdata[2] ? S_PRE : S_MAIN;
        cnt <= '0; sck_q <= 1'b0; bitc <= '0; idx <= '0;
      end

      case (st)
        S_PRE, S_MAIN: begin
          if (tick) begin
            cnt <= '0;
            if (!sck_q) begin
              sck_q <= 1'b1;
              rx    <= {rx[6:0], flash_miso};
            end else begin
              sck_q <= 1'b0;
              bitc  <= bitc + 3'd1;
              if (bitc == 3'd7) begin
                if (rd_cap) dbuf[j[5:2]][8*j[1:0] +: 8] <= rx;
                idx <= idx + 7'd1;
                if (frame_end) begin
                  idx <= '0;
                  if (st == S_PRE) st <= S_GAP;
                  else begin
                    st     <= S_IDLE;
                    done_q <= 1'b1;
                  end
                end
              end
            end
          end else cnt <= cnt + CW'(1);
        end
        S_GAP: begin
          if (cnt == CW'(GAP_T - 1)) begin
            cnt <= '0;
            st  <= S_MAIN;
          end else cnt <= cnt + CW'(1);
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/spi_menu_engine_chk.sv
module spi_menu_engine_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        busy,
  input logic        done,
  input logic        err,
  input logic        lock,
  input logic        go_wr,
  input logic        cs_n,
  input logic        sck,
  input logic [63:0] menu,
  input logic [15:0] types,
  input logic [15:0] pre
);
  p_sck_idle_r5: assert property (@(posedge clk) disable iff (!rst_n) cs_n |-> !sck)
    else $error("sck high with cs_n high");
  p_cs_idle_r6: assert property (@(posedge clk) disable iff (!rst_n) !busy |-> cs_n)
    else $error("cs_n low while idle");
  p_done_end_r6: assert property (@(posedge clk) disable iff (!rst_n) $fell(busy) |-> done)
    else $error("cycle ended without done");
  p_go_busy_err_r7: assert property (@(posedge clk) disable iff (!rst_n) (go_wr && busy) |=> err)
    else $error("go during busy did not flag error");
  p_lock_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n) lock |=> lock)
    else $error("lock dropped");
  p_locked_tables_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (lock && $past(lock)) |-> ($stable(menu) && $stable(types) && $stable(pre)))
    else $error("locked table changed");
endmodule

bind spi_menu_engine spi_menu_engine_chk u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done_q), .err(err_q), .lock(lock_q),
  .go_wr(go), .cs_n(flash_cs_n), .sck(flash_sck), .menu(menu), .types(types), .pre(pre_ops)
);

// File: tb/sim_spi_menu_engine.sv
`timescale 1ns/1ps
module sim_spi_menu_engine;
  localparam int CLK_DIV = 2;
  localparam int GAP_SCK = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic        we = 1'b0;
  logic [4:0]  ra = '0;
  logic [31:0] wd = '0;
  logic [31:0] rdv;
  logic        sck, cs_n, mosi, miso;

  spi_menu_engine #(.CLK_DIV(CLK_DIV), .GAP_SCK(GAP_SCK)) u0 (
    .clk(clk), .rst_n(rst_n), .reg_we(we), .reg_addr(ra), .reg_wdata(wd), .reg_rdata(rdv),
    .flash_sck(sck), .flash_cs_n(cs_n), .flash_mosi(mosi), .flash_miso(miso));

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  function automatic logic [7:0] pat(input int k);
    return 8'((k * 37 + 17) & 255);
  endfunction

  // behavioural flash model
  logic [7:0] cap_b[$];
  int cap_len[$];
  int cap_gap[$];
  int cur_len = 0, bitn = 0, hi_cnt = 0, sck_bad = 0;
  logic [7:0] shreg = '0;
  logic [7:0] curp;
  assign curp = pat(cur_len);
  assign miso = cs_n ? 1'b0 : curp[3'(7 - bitn)];

  always @(negedge cs_n or posedge sck) begin
    if (sck === 1'b1) begin
      if (cs_n === 1'b0) begin
        shreg = {shreg[6:0], mosi};
        bitn++;
        if (bitn == 8) begin
          cap_b.push_back(shreg);
          cur_len++;
          bitn = 0;
        end
      end
    end else begin
      cap_gap.push_back(hi_cnt);
      cur_len = 0;
      bitn = 0;
    end
  end
  always @(posedge cs_n) cap_len.push_back(cur_len);
  always @(negedge clk) begin
    if (cs_n === 1'b1) hi_cnt++; else hi_cnt = 0;
    if (rst_n && cs_n === 1'b1 && sck !== 1'b0) sck_bad++;
  end

  logic [7:0] exp_b[$];
  int exp_len[$];

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] expv, input string what);
    n_chk++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, expv);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); we = 1'b1; ra = a; wd = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk); ra = a; #1 d = rdv;
  endtask

  task automatic wait_idle();
    logic [31:0] s;
    for (int i = 0; i < 20000; i++) begin
      rd(5'd0, s);
      if (s[0] == 1'b0) break;
    end
  endtask

  function automatic logic [31:0] cw(input int sel, input bit atom, input bit psel, input bit dat, input int cnt);
    return (32'(dat) << 14) | (32'((cnt - 1) & 63) << 8) | (32'(sel) << 4) |
           (32'(psel) << 3) | (32'(atom) << 2) | 32'h2;
  endfunction

  task automatic clear_cap();
    cap_b.delete(); cap_len.delete(); cap_gap.delete(); exp_b.delete(); exp_len.delete();
  endtask

  task automatic exp_frame(input logic [7:0] b[$]);
    exp_len.push_back(b.size());
    foreach (b[i]) exp_b.push_back(b[i]);
  endtask

  task automatic cmp_frames(input string req, input string what);
    int bad = 0;
    check(req, 32'(cap_len.size()), 32'(exp_len.size()), {what, " frame count"});
    foreach (exp_len[i]) if (i < cap_len.size() && cap_len[i] != exp_len[i]) bad++;
    if (cap_b.size() != exp_b.size()) bad++;
    else foreach (exp_b[i]) if (cap_b[i] !== exp_b[i]) begin
      if (bad == 0) $display("  first byte mismatch at %0d: %h vs %h", i, cap_b[i], exp_b[i]);
      bad++;
    end
    check(req, 32'(bad), 32'd0, {what, " frame bytes"});
  endtask

  task automatic run(input logic [31:0] c);
    clear_cap();
    wr(5'd1, c);
    wait_idle();
    @(negedge clk);
  endtask

  initial begin
    #(5.0 * 190000);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    logic [7:0] q[$];
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R9 reset state
    rd(5'd0, r); check("R9", r, 32'h0, "status after reset");
    rd(5'd1, r); check("R9", r, 32'h0, "control after reset");
    check("R9", {31'b0, cs_n}, 32'h1, "cs_n after reset");
    check("R9", {31'b0, sck}, 32'h0, "sck after reset");

    wr(5'd5, 32'h9F020306);
    wr(5'd6, 32'hC70520D8);
    wr(5'd4, 32'h00004F39);
    wr(5'd3, 32'h00005006);

    // R1: plain opcode, entry 7 (type 1, no address)
    run(cw(7, 0, 0, 0, 1));
    q = '{8'hC7}; exp_frame(q);
    cmp_frames("R1", "entry 7 opcode only");

    // R2: type 0 sends no address even with address register loaded
    wr(5'd2, 32'h00AABBCC);
    run(cw(3, 0, 0, 0, 1));
    q = '{8'h9F}; exp_frame(q);
    cmp_frames("R2", "type 0 no address");

    // R3, R6: read without address, 3 data bytes
    clear_cap();
    wr(5'd1, cw(3, 0, 0, 1, 3));
    rd(5'd0, r); check("R6", r & 32'h1, 32'h1, "busy while running");
    wait_idle();
    @(negedge clk);
    q = '{8'h9F, 8'h00, 8'h00, 8'h00}; exp_frame(q);
    cmp_frames("R3", "read id");
    rd(5'd16, r); check("R3", r, {8'h00, pat(3), pat(2), pat(1)}, "read bytes packed");
    rd(5'd0, r); check("R6", r, 32'h4, "done sticky after end");
    rd(5'd1, r); check("R6", r & 32'h2, 32'h0, "go reads zero");
    wr(5'd0, 32'h4);
    rd(5'd0, r); check("R6", r, 32'h0, "done cleared by write one");

    // R2, R3: read with address, 5 bytes
    wr(5'd2, 32'h00123456);
    run(cw(1, 0, 0, 1, 5));
    q = '{8'h03, 8'h12, 8'h34, 8'h56, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00}; exp_frame(q);
    cmp_frames("R2", "read with address");
    rd(5'd16, r); check("R3", r, {pat(7), pat(6), pat(5), pat(4)}, "word 16 after addressed read");
    rd(5'd17, r); check("R3", r, {24'h0, pat(8)}, "word 17 after addressed read");

    // R4: prefix 0 then write with address, 6 bytes
    wr(5'd16, 32'h44332211);
    wr(5'd17, 32'h00006655);
    wr(5'd2, 32'h0000ABCD);
    run(cw(2, 1, 0, 1, 6));
    q = '{8'h06}; exp_frame(q);
    q = '{8'h02, 8'h00, 8'hAB, 8'hCD, 8'h11, 8'h22, 8'h33, 8'h44, 8'h55, 8'h66}; exp_frame(q);
    cmp_frames("R4", "prefix plus program");
    check("R4", 32'(cap_gap.size() > 1 && cap_gap[1] >= 2 * 2 * CLK_DIV), 32'h1, "gap between frames");

    // R4: prefix 1 selected
    run(cw(6, 1, 1, 0, 1));
    q = '{8'h50}; exp_frame(q);
    q = '{8'h05}; exp_frame(q);
    cmp_frames("R4", "second prefix opcode");

    // R3: full 64-byte write
    for (int w = 0; w < 16; w++)
      wr(5'(16 + w), {8'(w*12+7), 8'(w*12+5), 8'(w*12+3), 8'(w*12+1)});
    wr(5'd2, 32'h00010000);
    run(cw(5, 0, 0, 1, 64));
    q = '{8'h20, 8'h01, 8'h00, 8'h00};
    for (int k = 0; k < 64; k++) q.push_back(8'((k/4)*12 + (k%4)*2 + 1));
    exp_frame(q);
    cmp_frames("R3", "64 byte write");
    wr(5'd0, 32'h4);

    // R7: go while busy
    clear_cap();
    wr(5'd1, cw(7, 0, 0, 0, 1));
    wr(5'd1, cw(6, 0, 0, 0, 1));
    rd(5'd0, r); check("R7", r & 32'h9, 32'h9, "error set, still busy");
    wait_idle();
    @(negedge clk);
    q = '{8'hC7}; exp_frame(q);
    cmp_frames("R7", "only first cycle ran");
    wr(5'd0, 32'hC);
    rd(5'd0, r); check("R7", r, 32'h0, "error cleared by write one");

    // R8: lock
    wr(5'd0, 32'h8000);
    rd(5'd0, r); check("R8", r, 32'h8000, "lock reads back");
    wr(5'd5, 32'h0);
    wr(5'd4, 32'h0);
    wr(5'd3, 32'h0);
    rd(5'd5, r); check("R8", r, 32'h9F020306, "menu kept after lock");
    rd(5'd4, r); check("R8", r, 32'h4F39, "types kept after lock");
    run(cw(0, 1, 1, 0, 1));
    q = '{8'h50}; exp_frame(q);
    q = '{8'h06}; exp_frame(q);
    cmp_frames("R8", "locked tables still used");
    rd(5'd0, r); check("R8", r & 32'h8000, 32'h8000, "lock stays set");

    // R5: mode 0 idle level, observed on every clock
    check("R5", 32'(sck_bad), 32'h0, "sck low while cs_n high");

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule